// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is the digital core of a 256-byte serial memory that answers as a target on a two-wire I2C bus. The bus lines are oversampled by the system clock. The data line is driven only as an open-drain pull-down: one output requests that SDA be pulled low. The block finds START and STOP conditions and decodes a select byte that carries three strap bits. It keeps an 8-bit word pointer and gathers write data in an 8-byte page buffer. When the write is closed by a STOP, it runs a programming cycle that counts a fixed number of clock cycles. The array is a register array that holds FFh in every location after reset.

Reads take three forms. A current-address read goes straight to a select byte with the read bit set. A random read first sends a dummy write of the word pointer, followed by a repeated START. A sequential read continues for as long as the controller acknowledges each byte. While the programming cycle runs, the block leaves the bus alone. A controller can therefore poll with the select byte until it sees an acknowledge. A write-protect input that is high when the STOP arrives cancels the programming cycle.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, every one of the 256 locations reads back as 8'hFF, and `sda_pull_o` is low.
- R2: The block acknowledges a select byte, by pulling SDA low during the ninth clock, only when its upper seven bits are 4'b1010 followed by `strap_i[2:0]`. The least significant bit is the read (1) or write (0) flag. Any other select byte gets no acknowledge, and the block then ignores the bus until the next START.
- R3: A write sends the select byte, then the word address, then data bytes. The STOP that ends it starts a programming cycle of `PROG_CYCLES` clocks. At the end of that cycle the bytes are stored at their addresses.
- R4: Within one write, the low 3 address bits advance after each data byte and wrap inside the aligned 8-byte page. The upper 5 bits stay fixed. When more than 8 bytes are sent, the later bytes overwrite the earlier ones at the same page positions.
- R5: While a programming cycle runs, the block does not acknowledge a select byte. Once the cycle has ended, it acknowledges again.
- R6: If `wp_i` is high at the STOP that closes a write, no programming cycle starts and the memory is unchanged.
- R7: A random read returns the byte at the word address that was sent in the dummy write.
- R8: A current-address read returns the byte at the location after the last byte read.
- R9: During a sequential read, the address advances by one after each byte and wraps from 8'hFF to 8'h00. A controller NACK ends the read.
- R10: A STOP that arrives partway through a data byte, with no complete data byte acknowledged, starts no programming cycle. The block acknowledges at once, and the memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | High requests that SDA be pulled low |
| strap_i | input | 3 | Address strap bits compared against select bits 3..1 |
| wp_i | input | 1 | Write protect, sampled at the STOP that closes a write |

## Verification
The hardest situation to reach is one where the controller addresses the block while a programming cycle is still running. The bench issues a START and select byte right after the STOP of a write, within far fewer clocks than the programming window, and expects a NACK. It then waits past the window and expects an acknowledge. A second hard case is a STOP partway through a data byte. The bench sends four data bits and then a STOP, and then readdresses the block at once to show that no busy window was opened.

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int PROG_CYCLES = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(PROG_CYCLES + 1);
  localparam logic [ADDR_W-1:0] A_ONE = 1;
  localparam logic [PAGE_W-1:0] P_ONE = 1;

  typedef enum logic [2:0] {IDLE, RX, ACK, TX, TXACK, WAITS, PROG} st_t;
  typedef enum logic [1:0] {PH_DEV, PH_ADDR, PH_DATA, PH_READ} ph_t;

  st_t state;
  ph_t phase;
  logic scl_q, scl_p, sda_q, sda_p;
  logic [7:0] sh;
  logic [3:0] bitcnt;
  logic [ADDR_W-1:0] addr;
  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];
  logic [PAGE-1:0] vld;
  logic [TW-1:0] timer;
  logic oe;

  wire scl_rise = scl_q & ~scl_p;
  wire scl_fall = ~scl_q & scl_p;
  wire start_c  = scl_q & scl_p & sda_p & ~sda_q;
  wire stop_c   = scl_q & scl_p & ~sda_p & sda_q;
  wire [7:0] rd = mem[addr];
  wire sel_ok   = sh[7:1] == {4'b1010, strap_i};
  wire can_prog = state == RX && phase == PH_DATA && bitcnt <= 4'd1 && |vld && !wp_i;

  assign sda_pull_o = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= IDLE; phase <= PH_DEV;
      scl_q <= 1'b1; scl_p <= 1'b1; sda_q <= 1'b1; sda_p <= 1'b1;
      sh <= '0; bitcnt <= '0; addr <= '0; vld <= '0; timer <= '0; oe <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= 8'h00;
    end else begin
      scl_q <= scl_i; scl_p <= scl_q; sda_q <= sda_i; sda_p <= sda_q;
      if (state == PROG) begin
        if (timer == TW'(PROG_CYCLES - 1)) begin
          for (int i = 0; i < PAGE; i++)
            if (vld[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
          vld <= '0; timer <= '0; state <= IDLE;
        end else begin
          timer <= timer + TW'(1);
        end
      end else if (start_c) begin
        state <= RX; phase <= PH_DEV; bitcnt <= '0; vld <= '0; oe <= 1'b0;
      end else if (stop_c) begin
        oe <= 1'b0; timer <= '0;
        if (can_prog) state <= PROG;
        else begin state <= IDLE; vld <= '0; end
      end else begin
        case (state)
          RX: begin
            if (scl_rise && bitcnt < 4'd8) begin
              sh <= {sh[6:0], sda_q};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (phase)
                PH_DEV: begin
                  if (sel_ok) begin
                    oe <= 1'b1; state <= ACK;
                    phase <= sh[0] ? PH_READ : PH_ADDR;
                  end else state <= IDLE;
                end
                PH_ADDR: begin
                  oe <= 1'b1; state <= ACK; addr <= sh[ADDR_W-1:0]; phase <= PH_DATA;
                end
                PH_DATA: begin
                  oe <= 1'b1; state <= ACK;
                  pbuf[addr[PAGE_W-1:0]] <= sh;
                  vld[addr[PAGE_W-1:0]] <= 1'b1;
                  addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + P_ONE;
                end
                default: state <= IDLE;
              endcase
            end
          end
          ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (phase == PH_READ) begin
                sh <= rd; oe <= ~rd[7]; state <= TX;
              end else begin
                oe <= 1'b0; state <= RX;
              end
            end
          end
          TX: begin
            if (scl_rise) bitcnt <= bitcnt + 4'd1;
            else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                oe <= 1'b0; state <= TXACK; addr <= addr + A_ONE; bitcnt <= '0;
              end else begin
                oe <= ~sh[6]; sh <= {sh[6:0], 1'b0};
              end
            end
          end
          TXACK: begin
            if (scl_rise) begin
              if (sda_q) state <= WAITS;
              else bitcnt <= 4'd1;
            end else if (scl_fall && bitcnt == 4'd1) begin
              sh <= rd; oe <= ~rd[7]; state <= TX; bitcnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_busy_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state == PROG |-> !sda_pull_o);

  p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == IDLE |-> !sda_pull_o);

  p_select_prefix_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ACK && $past(state) == RX && (phase == PH_READ || phase == PH_ADDR))
      |-> $past(sh[7:4]) == 4'b1010);

  p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PROG && $past(state) != PROG) |-> !$past(wp_i));

  p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && $past(phase) == PH_DATA)
      |-> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));
endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;
  localparam int PROG = 300;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_c = 1'b1;
  logic wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic pull;
  wire sda_line = sda_c & ~pull;

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_mem [256];

  always #2.5 clk = ~clk;

  i2c_eeprom_target #(.ADDR_W(8), .PAGE_W(3), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(pull), .strap_i(strap), .wp_i(wp));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic bstart();
    sda_c = 1'b1; tick(Q); scl = 1'b1; tick(Q); sda_c = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_c = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_c = 1'b1; tick(Q);
  endtask

  task automatic wbit(input logic b);
    sda_c = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
  endtask

  task automatic rbit(output logic b);
    sda_c = 1'b1; tick(Q); scl = 1'b1; tick(Q); b = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(ack);
  endtask

  task automatic rbyte(output logic [7:0] d, input logic last);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(last);
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic page_write(input logic [7:0] a, input int n, input int s, input logic upd);
    logic ack;
    bstart();
    wbyte(8'hAA, ack); check("R3 select ack", ack, 0);
    wbyte(a, ack);
    for (int i = 0; i < n; i++) begin
      wbyte(pat(s, i), ack);
      if (upd) exp_mem[{a[7:3], 3'(a[2:0] + 3'(i))}] = pat(s, i);
    end
    bstop();
    tick(PROG + 20);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bstart();
    wbyte(8'hAA, ack);
    wbyte(a, ack);
    bstart();
    wbyte(8'hAB, ack); check(req, ack, 0);
    for (int i = 0; i < n; i++) begin
      rbyte(d, i == n - 1);
      check(req, d, exp_mem[8'(a + 8'(i))]);
    end
    bstop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'hFF;
    tick(5);
    check("R1 pull low in reset", pull, 0);
    rst_n = 1'b1;
    tick(5);
    check("R1 pull low after reset", pull, 0);

    rand_read(8'h00, 256, "R1 erased read");

    for (int j = 0; j < 8; j++) begin
      bstart();
      wbyte({4'hA, 3'(j), 1'b0}, ack);
      check("R2 strap match", ack, (j == 5) ? 0 : 1);
      bstop();
    end
    for (int p = 0; p < 16; p++) begin
      bstart();
      wbyte({4'(p), strap, 1'b1}, ack);
      check("R2 prefix match", ack, (p == 10) ? 0 : 1);
      if (p == 10) rbyte(d, 1'b1);
      bstop();
    end

    for (int k = 0; k < 12; k++) page_write(8'(k * 21 + 3), 1, k, 1'b1);
    for (int k = 0; k < 12; k++) rand_read(8'(k * 21 + 3), 1, "R3 byte write R7");

    page_write(8'h13, 5, 40, 1'b1);
    rand_read(8'h10, 8, "R4 page wrap");
    page_write(8'h2E, 11, 41, 1'b1);
    rand_read(8'h28, 8, "R4 overwrite");

    bstart();
    wbyte(8'hAA, ack); wbyte(8'h40, ack); wbyte(8'h5C, ack);
    exp_mem[8'h40] = 8'h5C;
    bstop();
    bstart();
    wbyte(8'hAA, ack); check("R5 busy nack", ack, 1);
    bstop();
    tick(PROG + 20);
    bstart();
    wbyte(8'hAA, ack); check("R5 ready ack", ack, 0);
    bstop();
    rand_read(8'h40, 1, "R5 stored");

    wp = 1'b1;
    page_write(8'h80, 3, 50, 1'b0);
    wp = 1'b0;
    rand_read(8'h80, 3, "R6 protected");

    bstart();
    wbyte(8'hAA, ack); wbyte(8'h90, ack);
    for (int i = 0; i < 4; i++) wbit(1'b0);
    bstop();
    bstart();
    wbyte(8'hAA, ack); check("R10 no busy", ack, 0);
    bstop();
    rand_read(8'h90, 1, "R10 unchanged");

    page_write(8'hFC, 4, 60, 1'b1);
    page_write(8'h00, 2, 61, 1'b1);
    rand_read(8'hFC, 6, "R9 wrap seq");
    bstart();
    wbyte(8'hAB, ack); check("R8 select", ack, 0);
    rbyte(d, 1'b1);
    check("R8 current addr", d, exp_mem[8'h02]);
    bstop();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule